// File: doc/BRIEF.md
# Serial Offset Register Loader

This block fills the four threshold offsets that a dual-direction FIFO uses for its almost-full and almost-empty flags. The offsets arrive over one serial data pin instead of a wide parallel bus. The offset registers are called Y1, X1, Y2 and X2.

Serial programming is chosen by the configuration pins during master reset. After reset, one bit is taken on each write-side clock edge during which the active-low serial enable is asserted. The stream is continuous and most significant bit first, and it covers all four registers. While the stream is incomplete, the input-ready flags of both write ports stay LOW, so no data enters either FIFO before its thresholds are valid.

The Port A ready flag is released in the `clk_a` domain. The Port C ready flag is released in the `clk_c` domain, after the completion has passed through a flop synchronizer.

Top module: `offset_serial_loader`

## Requirements
- R1: Serial loading is enabled only when, on the last `clk_a` rising edge with `rst_n` LOW, `mode_sel` is 0, `sdata` is 0, `sen_n` is 1 and `par_sel` is 0. Any other combination leaves it disabled until the next reset.
- R2: With serial loading enabled and reset released, exactly one bit of `sdata` is taken on each `clk_a` rising edge at which `sen_n` is 0. Edges with `sen_n` at 1 take nothing.
- R3: The stream is MSB first in the fixed order `off_y1`, `off_x1`, `off_y2`, `off_x2`. The first bit lands in the top bit of `off_y1` and the last bit lands in bit 0 of `off_x2`. Each field is OFF_W = clog2(DEPTH) bits wide (11 for the default DEPTH of 2048).
- R4: A complete load is exactly 4*OFF_W bits (44 by default). After one bit fewer than that, both ready flags remain LOW.
- R5: `rdy_a` is LOW while loading and becomes HIGH at the `clk_a` rising edge that follows the edge taking the last bit. Once HIGH, it stays HIGH until reset.
- R6: `rdy_c` is LOW whenever `rdy_a` is LOW. It becomes HIGH within three `clk_c` rising edges after `rdy_a` rises, through a two-stage synchronizer.
- R7: After a complete load, further enabled bits change neither the offsets nor the flags until the next master reset.
- R8: When `par_sel` is 1 at reset (interspersed parity), serial loading is disabled. In every disabled case, the offsets stay 0 whatever happens on `sdata`/`sen_n`, and `rdy_a` becomes HIGH at the first `clk_a` rising edge after reset release.
- R9: While `rst_n` is LOW, `rdy_a` and `rdy_c` are 0 and all four offsets are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A write clock; serial bits are taken on its rising edge |
| clk_c | input | 1 | Port C write clock |
| rst_n | input | 1 | Master reset, active LOW, asynchronous assert |
| mode_sel | input | 1 | Flag-programming mode select, must be 0 for serial load |
| par_sel | input | 1 | Interspersed parity configuration, 1 forbids serial load |
| sdata | input | 1 | Serial data; also a configuration pin during reset |
| sen_n | input | 1 | Serial enable, active LOW; also a configuration pin during reset |
| off_y1 | output | OFF_W | Almost-empty offset, Port B side |
| off_x1 | output | OFF_W | Almost-full offset, Port A side |
| off_y2 | output | OFF_W | Almost-empty offset, Port A side |
| off_x2 | output | OFF_W | Almost-full offset, Port C side |
| rdy_a | output | 1 | Port A input-ready, released in the clk_a domain |
| rdy_c | output | 1 | Port C input-ready, released in the clk_c domain |

## Verification
The assertions assume that the configuration pins are steady around the final `clk_a` edge of reset, and that `rst_n` is released away from both clock edges. The stimulus meets this by changing every input on the falling edge of `clk_a` and by holding reset for several cycles. The check that `rdy_c` implies `rdy_a` relies on `rdy_a` never falling except through the asynchronous reset that also clears the synchronizer. The bench therefore pulses reset only while both clocks are running. Offset values sent by the bench stay inside the legal range of 1 to DEPTH-4, apart from deliberately extreme patterns that check the bit order.

// File: rtl/offset_serial_loader.sv
module offset_serial_loader #(
  parameter int DEPTH       = 2048,
  parameter int SYNC_STAGES = 2,
  localparam int OFF_W      = $clog2(DEPTH)
) (
  input  logic             clk_a,
  input  logic             clk_c,
  input  logic             rst_n,
  input  logic             mode_sel,
  input  logic             par_sel,
  input  logic             sdata,
  input  logic             sen_n,
  output logic [OFF_W-1:0] off_y1,
  output logic [OFF_W-1:0] off_x1,
  output logic [OFF_W-1:0] off_y2,
  output logic [OFF_W-1:0] off_x2,
  output logic             rdy_a,
  output logic             rdy_c
);

  localparam int TOTAL = 4 * OFF_W;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL);

  logic                   serial_mode;
  logic [CNT_W-1:0]       cnt;
  logic [TOTAL-1:0]       sr;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   full_load;
  logic                   take_bit;

  assign full_load = (cnt == LAST);
  assign take_bit  = serial_mode && !sen_n && !full_load;

  always_ff @(posedge clk_a)
    if (!rst_n)
      serial_mode <= !mode_sel && !sdata && sen_n && !par_sel;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      sr  <= '0;
    end else if (take_bit) begin
      cnt <= cnt + 1'b1;
      sr  <= {sr[TOTAL-2:0], sdata};
    end

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n)
      rdy_a <= 1'b0;
    else if (full_load || !serial_mode)
      rdy_a <= 1'b1;

  always_ff @(posedge clk_c or negedge rst_n)
    if (!rst_n)
      sync_q <= '0;
    else
      sync_q <= {sync_q[SYNC_STAGES-2:0], rdy_a};

  assign rdy_c  = sync_q[SYNC_STAGES-1];
  assign off_y1 = sr[4*OFF_W-1 -: OFF_W];
  assign off_x1 = sr[3*OFF_W-1 -: OFF_W];
  assign off_y2 = sr[2*OFF_W-1 -: OFF_W];
  assign off_x2 = sr[OFF_W-1:0];

  AST_ONE_BIT_STEP: assert property (@(posedge clk_a) disable iff (!rst_n)
    cnt != $past(cnt) |-> cnt == CNT_W'($past(cnt) + 1'b1)); // R2
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk_a) disable iff (!rst_n)
    $past(sen_n) && $past(rst_n) |-> $stable(sr)); // R2
  AST_RDYA_WAITS: assert property (@(posedge clk_a) disable iff (!rst_n)
    serial_mode && !full_load |-> !rdy_a); // R5
  AST_RDYA_STICKY: assert property (@(posedge clk_a) disable iff (!rst_n)
    rdy_a |=> rdy_a); // R5
  AST_LOAD_FROZEN: assert property (@(posedge clk_a) disable iff (!rst_n)
    full_load |=> full_load && $stable(sr)); // R7
  AST_NO_SERIAL_NO_DATA: assert property (@(posedge clk_a) disable iff (!rst_n)
    !serial_mode |-> sr == '0); // R8
  AST_RDYC_AFTER_A: assert property (@(posedge clk_c) disable iff (!rst_n)
    rdy_c |-> rdy_a); // R6

  initial begin
    assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES below 2"); // R6
  end

endmodule

// File: tb/offset_serial_loader_tb.sv
module offset_serial_loader_tb;
  localparam int DEPTH = 2048;
  localparam int W     = $clog2(DEPTH);
  localparam int TOTAL = 4 * W;

  logic clk_a = 0, clk_c = 0, rst_n = 0;
  logic mode_sel = 0, par_sel = 0, sdata = 0, sen_n = 1;
  logic [W-1:0] off_y1, off_x1, off_y2, off_x2;
  logic rdy_a, rdy_c;
  int n_chk = 0, n_fail = 0;

  always #4 clk_a = ~clk_a;
  always #6 clk_c = ~clk_c;

  offset_serial_loader #(.DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
    .clk_a(clk_a), .clk_c(clk_c), .rst_n(rst_n), .mode_sel(mode_sel),
    .par_sel(par_sel), .sdata(sdata), .sen_n(sen_n),
    .off_y1(off_y1), .off_x1(off_x1), .off_y2(off_y2), .off_x2(off_x2),
    .rdy_a(rdy_a), .rdy_c(rdy_c));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m, input logic d, input logic s, input logic p);
    @(negedge clk_a);
    rst_n = 0; mode_sel = m; sdata = d; sen_n = s; par_sel = p;
    repeat (4) @(negedge clk_a);
    chk("R9 rdy_a in reset", rdy_a, 0);
    chk("R9 rdy_c in reset", rdy_c, 0);
    chk("R9 offsets in reset", {off_y1, off_x1, off_y2, off_x2}, 0);
    rst_n = 1; mode_sel = 0; sdata = 0; sen_n = 1; par_sel = 0;
  endtask

  task automatic shift_bits(input logic [63:0] v, input int hi, input int lo, input bit gap);
    for (int i = hi; i >= lo; i--) begin
      sdata = v[i]; sen_n = 0;
      @(negedge clk_a);
      sen_n = 1;
      if (gap && (i % 3 == 0)) begin
        sdata = ~v[i];
        repeat (2) @(negedge clk_a);
      end
    end
    sen_n = 1;
  endtask

  task automatic wait_rdy_c(input string req);
    logic seen = 0;
    for (int k = 0; k < 4 && !seen; k++) begin
      @(posedge clk_c); #1;
      seen = rdy_c;
    end
    chk(req, seen, 1);
  endtask

  task automatic t_load(input logic [W-1:0] y1, x1, y2, x2, input bit gap);
    logic [63:0] v;
    v = 64'({y1, x1, y2, x2});
    shift_bits(v, TOTAL-1, 1, gap);
    repeat (3) @(negedge clk_a);
    chk("R4 rdy_a low one bit short", rdy_a, 0);
    chk("R6 rdy_c low one bit short", rdy_c, 0);
    shift_bits(v, 0, 0, 0);
    chk("R5 rdy_a low at last bit edge", rdy_a, 0);
    @(negedge clk_a);
    chk("R5 rdy_a high next edge", rdy_a, 1);
    chk("R3 off_y1", off_y1, y1);
    chk("R3 off_x1", off_x1, x1);
    chk("R3 off_y2", off_y2, y2);
    chk("R3 off_x2", off_x2, x2);
    wait_rdy_c("R6 rdy_c released");
  endtask

  task automatic t_extra(input logic [W-1:0] y1, x1, y2, x2);
    shift_bits(64'h2A5, 9, 0, 0);
    repeat (2) @(negedge clk_a);
    chk("R7 offsets frozen", {off_y1, off_x1, off_y2, off_x2}, {y1, x1, y2, x2});
    chk("R7 rdy_a held", rdy_a, 1);
    chk("R7 rdy_c held", rdy_c, 1);
  endtask

  task automatic t_gap_counts();
    do_reset(0, 0, 1, 0);
    shift_bits(64'h5, 2, 0, 0);
    repeat (5) @(negedge clk_a);
    chk("R2 idle edges take nothing", off_x2, 11'h5);
    chk("R1 serial mode keeps rdy_a low", rdy_a, 0);
  endtask

  task automatic t_disabled(input string req, input logic m, input logic d, input logic s, input logic p);
    do_reset(m, d, s, p);
    @(negedge clk_a);
    chk({req, " rdy_a at first edge"}, rdy_a, 1);
    shift_bits(64'hFFFF, 15, 0, 0);
    @(negedge clk_a);
    chk({req, " offsets stay 0"}, {off_y1, off_x1, off_y2, off_x2}, 0);
    wait_rdy_c({req, " rdy_c"});
  endtask

  initial begin
    fork
      begin
        do_reset(0, 0, 1, 0);
        @(negedge clk_a);
        chk("R9 offsets after reset", {off_y1, off_x1, off_y2, off_x2}, 0);
        chk("R1 rdy_a low in serial mode", rdy_a, 0);
        t_load(11'h123, 11'h456, 11'h0F1, 11'h7AB, 1);
        t_extra(11'h123, 11'h456, 11'h0F1, 11'h7AB);
        do_reset(0, 0, 1, 0);
        t_load(11'd1, 11'(DEPTH-4), 11'h400, 11'h001, 0);
        t_extra(11'd1, 11'(DEPTH-4), 11'h400, 11'h001);
        t_gap_counts();
        t_disabled("R8 parity", 0, 0, 1, 1);
        t_disabled("R1 mode_sel", 1, 0, 1, 0);
        t_disabled("R1 sdata high", 0, 1, 1, 0);
        t_disabled("R1 sen_n low", 0, 0, 0, 0);
      end
      begin
        repeat (20000) @(posedge clk_a);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule